// File: doc/BRIEF.md
# Clock Source Selector with Output Mask

This block picks one of several incoming clocks and drives it onto a single clock output for a downstream domain. Source 0 is the low-frequency reference clock, and selecting it bypasses any PLL output. The other sources are typically PLL outputs. A parameter chooses one of two implementations.

The safe implementation hands over between two running clocks without ever producing a runt pulse. It first turns the old source off at one of that source's falling edges. It then turns the new source on at one of the new source's falling edges. A status word tells software whether the handover has finished. If the new source is not toggling, the handover waits indefinitely.

The masked implementation is a plain combinational multiplexer, which can glitch when the selection moves. It is therefore followed by an output gate driven by an enable bit. Software clears the enable, changes the selection, and then sets the enable again. The gate only opens or closes while the multiplexed clock is low.

Top module: `clk_src_select`

## Requirements
- R1: In the safe variant, no high or low phase on `clk_out` is shorter than the shortest half period among the two sources taking part in a switch. A source's gate opens or closes only while that source's clock is low.
- R2: In the safe variant, at most one source is gated onto the output at any time.
- R3: Whenever bit NUM_SRC of `sel_status` is 0, bits NUM_SRC-1:0 are one-hot and mark the source in use, and `clk_out` follows that source's clock.
- R4: In the safe variant, when `sel` moves to a different source, `sel_status` reads 4'b1000 (only bit NUM_SRC set) from that moment until the new source is gated on.
- R5: In the safe variant, if the newly selected source is stopped, `sel_status` stays at 4'b1000 and `clk_out` stays low. Once the source runs again, the switch completes.
- R6: After reset, source 0 is selected, `sel_status` reads 4'b0001 and the output is unmasked.
- R7: A `sel` value of 0 routes the reference clock (source 0) to the output. Any `sel` value of NUM_SRC or above also selects source 0.
- R8: In the masked variant, `out_en`=0 holds `clk_out` low. Changes to `out_en` take effect only while the selected clock is low, so no pulse is shortened.
- R9: In the masked variant, `sel_status` shows the one-hot code of the new selection immediately. After the mask, select, unmask sequence, `clk_out` follows the new source.
- R10: In the safe variant, `out_en` has no effect on `clk_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_src | input | NUM_SRC | Candidate clocks; bit 0 is the reference (bypass) clock |
| sel | input | SEL_W | Requested source index |
| out_en | input | 1 | Output enable for the masked variant; 0 forces the output low |
| clk_out | output | 1 | Selected clock |
| sel_status | output | NUM_SRC+1 | One-hot of the source in use, or only the top bit set while a switch is pending |

## Verification
Some properties are checked by assertions on every cycle:
- At most one gate is ever open.
- Gates and the output enable only change while their own clock is low.
- While the status reads stable, the output matches the clock that the status points at.

Other behaviour only shows up in the bench's scenarios. These are the full handover timing and the absence of runt pulses measured on the output, the indefinite stall on a stopped target, the bypass mapping of out-of-range selects, and the masked variant's output staying low through the mask, select, unmask sequence.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;

   typedef enum logic [0:0] {
      KIND_SAFE   = 1'b0,
      KIND_MASKED = 1'b1
   } sel_kind_e;

   localparam int DEFAULT_SYNC_DEPTH = 2;

endpackage

// File: rtl/clksel_decode.sv
`timescale 1ns/1ps
module clksel_decode #(
   parameter int NUM_SRC = 3,
   parameter int SEL_W   = 2
) (
   input  logic [SEL_W-1:0]   sel,
   output logic [NUM_SRC-1:0] onehot
);

   always_comb begin
      onehot = '0;
      if (int'(sel) < NUM_SRC) begin
         onehot[sel] = 1'b1;
      end else begin
         onehot[0] = 1'b1;
      end
   end

endmodule

// File: rtl/clksel_lane.sv
`timescale 1ns/1ps
module clksel_lane #(
   parameter int SYNC_DEPTH = 2,
   parameter bit RST_ON     = 1'b0
) (
   input  logic clk_i,
   input  logic rst_n,
   input  logic want_i,
   output logic gate_o,
   output logic busy_o
);

   logic [SYNC_DEPTH-1:0] sync_q;

   if (SYNC_DEPTH < 2) begin : g_bad_depth
      $error("clksel_lane: SYNC_DEPTH must be at least 2");
   end

   always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= {SYNC_DEPTH{RST_ON}};
      end else begin
         sync_q <= {sync_q[SYNC_DEPTH-2:0], want_i};
      end
   end

   always_ff @(negedge clk_i or negedge rst_n) begin
      if (!rst_n) begin
         gate_o <= RST_ON;
      end else begin
         gate_o <= sync_q[SYNC_DEPTH-1];
      end
   end

   assign busy_o = (|sync_q) | gate_o;

   always @(gate_o) begin
      if (rst_n) begin
         assert_gate_edge_low_R1: assert (!clk_i)
            else $error("gate moved while its clock was high");
      end
   end

endmodule

// File: rtl/clksel_safe.sv
`timescale 1ns/1ps
module clksel_safe #(
   parameter int NUM_SRC    = 3,
   parameter int SYNC_DEPTH = 2
) (
   input  logic [NUM_SRC-1:0] clk_src,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] sel_onehot,
   output logic               clk_o,
   output logic [NUM_SRC-1:0] gate_vec
);

   logic [NUM_SRC-1:0] busy_vec;
   logic [NUM_SRC-1:0] want_vec;
   logic [NUM_SRC-1:0] gated;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
      localparam logic [NUM_SRC-1:0] SELF = NUM_SRC'(1) << i;

      assign want_vec[i] = sel_onehot[i] & ~(|(busy_vec & ~SELF));

      clksel_lane #(
         .SYNC_DEPTH (SYNC_DEPTH),
         .RST_ON     (i == 0)
      ) u_lane (
         .clk_i  (clk_src[i]),
         .rst_n  (rst_n),
         .want_i (want_vec[i]),
         .gate_o (gate_vec[i]),
         .busy_o (busy_vec[i])
      );

      assign gated[i] = clk_src[i] & gate_vec[i];
   end

   assign clk_o = |gated;

   always_comb begin
      if (rst_n) begin
         assert_one_gate_R2: assert ($onehot0(gate_vec))
            else $error("more than one source gated on");
      end
   end

endmodule

// File: rtl/clksel_masked.sv
`timescale 1ns/1ps
module clksel_masked #(
   parameter int NUM_SRC    = 3,
   parameter int SYNC_DEPTH = 2
) (
   input  logic [NUM_SRC-1:0] clk_src,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] sel_onehot,
   input  logic               out_en,
   output logic               clk_o
);

   logic                  clk_mux;
   logic [SYNC_DEPTH-1:0] en_sync_q;
   logic                  en_q;

   assign clk_mux = |(clk_src & sel_onehot);

   always_ff @(posedge clk_mux or negedge rst_n) begin
      if (!rst_n) begin
         en_sync_q <= '1;
      end else begin
         en_sync_q <= {en_sync_q[SYNC_DEPTH-2:0], out_en};
      end
   end

   always_ff @(negedge clk_mux or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b1;
      end else begin
         en_q <= en_sync_q[SYNC_DEPTH-1];
      end
   end

   assign clk_o = clk_mux & en_q;

   always @(en_q) begin
      if (rst_n) begin
         assert_mask_edge_low_R8: assert (!clk_mux)
            else $error("output enable moved while clock was high");
      end
   end

endmodule

// File: rtl/clk_src_select.sv
`timescale 1ns/1ps
module clk_src_select
   import clksel_pkg::*;
#(
   parameter sel_kind_e KIND       = KIND_SAFE,
   parameter int        NUM_SRC    = 3,
   parameter int        SYNC_DEPTH = DEFAULT_SYNC_DEPTH,
   localparam int       SEL_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
   localparam int       STAT_W     = NUM_SRC + 1
) (
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] clk_src,
   input  logic [SEL_W-1:0]   sel,
   input  logic               out_en,
   output logic               clk_out,
   output logic [STAT_W-1:0]  sel_status
);

   if (NUM_SRC < 2) begin : g_bad_num
      $error("clk_src_select: NUM_SRC must be at least 2");
   end
   if (SYNC_DEPTH < 2) begin : g_bad_sync
      $error("clk_src_select: SYNC_DEPTH must be at least 2");
   end

   logic [NUM_SRC-1:0] sel_dec;

   clksel_decode #(
      .NUM_SRC (NUM_SRC),
      .SEL_W   (SEL_W)
   ) u_decode (
      .sel    (sel),
      .onehot (sel_dec)
   );

   if (KIND == KIND_SAFE) begin : g_safe
      logic [NUM_SRC-1:0] gate_vec;
      logic               en_unused;

      assign en_unused = out_en;

      clksel_safe #(
         .NUM_SRC    (NUM_SRC),
         .SYNC_DEPTH (SYNC_DEPTH)
      ) u_safe (
         .clk_src    (clk_src),
         .rst_n      (rst_n),
         .sel_onehot (sel_dec),
         .clk_o      (clk_out),
         .gate_vec   (gate_vec)
      );

      assign sel_status = (gate_vec == sel_dec) ? {1'b0, gate_vec}
                                                : {1'b1, {NUM_SRC{1'b0}}};

      property p_out_follows;
         @(posedge clk_src[0]) disable iff (!rst_n)
            !sel_status[NUM_SRC] |->
               (clk_out == (|(clk_src & sel_status[NUM_SRC-1:0])));
      endproperty
      assert_out_follows_R3: assert property (p_out_follows)
         else $error("output differs from clock named by status");
   end else begin : g_masked
      clksel_masked #(
         .NUM_SRC    (NUM_SRC),
         .SYNC_DEPTH (SYNC_DEPTH)
      ) u_masked (
         .clk_src    (clk_src),
         .rst_n      (rst_n),
         .sel_onehot (sel_dec),
         .out_en     (out_en),
         .clk_o      (clk_out)
      );

      assign sel_status = {1'b0, sel_dec};
   end

endmodule

// File: tb/clk_src_select_tb.sv
`timescale 1ns/1ps
module clk_src_select_tb;
   import clksel_pkg::*;

   localparam realtime CLK_PERIOD = 10.0;
   localparam realtime MIN_HALF   = 3.0;
   localparam int      SETTLE     = 60;

   logic       rst_n   = 1'b0;
   logic [2:0] clk_src = 3'b000;
   logic [1:0] sel     = 2'd0;
   logic       out_en  = 1'b1;
   logic       run2    = 1'b1;

   logic       gf_out, mk_out;
   logic [3:0] gf_stat, mk_stat;

   int checks = 0;
   int errors = 0;
   int cur_src = 0;

   always #(CLK_PERIOD/2) clk_src[0] = ~clk_src[0];
   always #3 clk_src[1] = ~clk_src[1];
   always #7 if (run2 || clk_src[2]) clk_src[2] = ~clk_src[2];

   clk_src_select #(.KIND(KIND_SAFE), .NUM_SRC(3)) u_dut (
      .rst_n(rst_n), .clk_src(clk_src), .sel(sel), .out_en(out_en),
      .clk_out(gf_out), .sel_status(gf_stat));

   clk_src_select #(.KIND(KIND_MASKED), .NUM_SRC(3)) u_dut_mask (
      .rst_n(rst_n), .clk_src(clk_src), .sel(sel), .out_en(out_en),
      .clk_out(mk_out), .sel_status(mk_stat));

   bit      mon_on = 1'b0;
   realtime gf_last, mk_last;
   int      gf_viol = 0, mk_viol = 0;

   always @(gf_out) if (mon_on) begin
      if ($realtime - gf_last < MIN_HALF - 0.1) gf_viol++;
      gf_last = $realtime;
   end
   always @(mk_out) if (mon_on) begin
      if ($realtime - mk_last < MIN_HALF - 0.1) mk_viol++;
      mk_last = $realtime;
   end

   function automatic logic [3:0] exp_status(input logic [1:0] s);
      return (s < 2'd3) ? (4'b0001 << s) : 4'b0001;
   endfunction

   function automatic int exp_src(input logic [1:0] s);
      return (s < 2'd3) ? int'(s) : 0;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic follow(input bit masked, input int src, input int n,
                         output int miss);
      miss = 0;
      for (int k = 0; k < n; k++) begin
         #1;
         if ((masked ? mk_out : gf_out) !== clk_src[src]) miss++;
      end
   endtask

   task automatic low_hold(input bit masked, input int n, output int highs);
      highs = 0;
      for (int k = 0; k < n; k++) begin
         #1;
         if ((masked ? mk_out : gf_out) !== 1'b0) highs++;
      end
   endtask

   task automatic wait_gf(input logic [3:0] exp, input int limit, output bit ok);
      ok = 1'b0;
      for (int k = 0; k < limit; k++) begin
         if (gf_stat == exp) begin
            ok = 1'b1;
            break;
         end
         #1;
      end
   endtask

   task automatic do_switch(input logic [1:0] new_sel);
      int  miss;
      bit  ok;
      int  nsrc;
      nsrc = exp_src(new_sel);
      out_en = 1'b0;
      #SETTLE;
      low_hold(1'b1, 30, miss);
      check(miss == 0, "R8", "masked output high while masked", miss, 0);
      follow(1'b0, cur_src, 30, miss);
      check(miss == 0, "R10", "safe output disturbed by mask", miss, 0);
      sel = new_sel;
      #1;
      check(mk_stat == exp_status(new_sel), "R9", "masked status",
            mk_stat, exp_status(new_sel));
      if (nsrc != cur_src)
         check(gf_stat == 4'b1000, "R4", "pending status", gf_stat, 4'b1000);
      wait_gf(exp_status(new_sel), 400, ok);
      check(ok, "R3", "safe status settle", gf_stat, exp_status(new_sel));
      out_en = 1'b1;
      #SETTLE;
      follow(1'b0, nsrc, 60, miss);
      check(miss == 0, (new_sel == 2'd3) ? "R7" : "R3",
            "safe output follows source", miss, 0);
      follow(1'b1, nsrc, 60, miss);
      check(miss == 0, "R9", "masked output follows source", miss, 0);
      cur_src = nsrc;
   endtask

   initial begin : watchdog
      #1_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      int  miss;
      bit  ok;
      void'($urandom(32'd20240917));
      #0.5;
      #40;
      rst_n = 1'b1;
      #20;
      check(gf_stat == 4'b0001, "R6", "safe status after reset", gf_stat, 4'b0001);
      check(mk_stat == 4'b0001, "R6", "masked status after reset", mk_stat, 4'b0001);
      follow(1'b0, 0, 100, miss);
      check(miss == 0, "R6", "safe output is reference", miss, 0);
      follow(1'b1, 0, 100, miss);
      check(miss == 0, "R6", "masked output unmasked on reference", miss, 0);

      mon_on  = 1'b1;
      gf_last = $realtime - 100.0;
      mk_last = $realtime - 100.0;

      do_switch(2'd1);
      do_switch(2'd2);
      do_switch(2'd3);
      do_switch(2'd1);
      do_switch(2'd0);
      do_switch(2'd2);

      for (int it = 0; it < 25; it++) begin
         do_switch(2'($urandom % 4));
      end

      do_switch(2'd0);
      out_en = 1'b0;
      #SETTLE;
      run2 = 1'b0;
      #20;
      sel = 2'd2;
      #300;
      check(gf_stat == 4'b1000, "R5", "status with stopped target", gf_stat, 4'b1000);
      low_hold(1'b0, 100, miss);
      check(miss == 0, "R5", "output low with stopped target", miss, 0);
      run2 = 1'b1;
      wait_gf(4'b0100, 400, ok);
      check(ok, "R5", "switch completes after restart", gf_stat, 4'b0100);
      out_en = 1'b1;
      #SETTLE;
      follow(1'b0, 2, 60, miss);
      check(miss == 0, "R5", "safe output on restarted source", miss, 0);
      follow(1'b1, 2, 60, miss);
      check(miss == 0, "R9", "masked output on restarted source", miss, 0);
      cur_src = 2;

      check(gf_viol == 0, "R1", "runt phases on safe output", gf_viol, 0);
      check(mk_viol == 0, "R8", "shortened phases on masked output", mk_viol, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule